// File: doc/BRIEF.md
# Fault-Tolerant Event Completion Tracker

This block follows event trailers arriving from a set of data sources (18 by default) and decides when each event is finished. It keeps a bit matrix with one row per outstanding event (16 by default) and one column per source. Each row records which sources have already sent a trailer carrying that event's identifier. The oldest row always belongs to the expected event identifier, and each row after it belongs to the expected identifier plus its offset. Identifiers are 12 bits wide and are compared modulo 2^12, so the window wraps from the largest identifier back to zero.

When every enabled source has reported the expected event, the block writes that identifier into an internal first-in first-out queue of 128 entries and moves the window forward by one. A source that is switched off in the enable mask counts as having reported every event. The block also copes with faults. If a later event completes while the expected one is still missing trailers, the expected event is written out marked as abandoned. If a trailer arrives too far ahead of the window, the block goes into panic: it abandons the expected event and moves on. A trailer that falls behind the window is flagged as late. Early and late trailers raise a sticky interrupt record that holds the source number, the identifier, the kind of fault and an overrun bit.

A processor loads the starting identifier, and the hardware advances it from then on. A single source can be resynchronised by erasing its column. A queue write that finds the queue full is lost, and a sticky fatal flag records the loss.

Top module: `evt_tracker`

## Requirements
- R1: After reset the expected identifier is 0, the queue is empty (out_valid 0, fifo_full 0), fifo_fatal is 0 and no interrupt is pending.
- R2: A trailer is recorded at the clock edge where it is presented. If at a later edge every enabled source has reported the expected identifier, that identifier is queued with out_forced 0 at that edge and the expected identifier increases by one. At most one event retires per cycle.
- R3: A source whose src_en bit is 0 counts as having reported every event. With all src_en bits at 0, one event retires every cycle.
- R4: If any later row in the window is complete while the expected row is not, the expected identifier is queued with out_forced 1 and the window advances by one. This repeats once per cycle until the completed event retires normally.
- R5: A trailer from a valid source whose offset from the expected identifier (modulo 2^IDW) lies in [WIN, 2^(IDW-1)) is early. At that edge the expected identifier is queued (out_forced 1 if incomplete) and the window advances by one. The early trailer itself is not recorded.
- R6: A trailer is late, and is not recorded, if its offset lies in [2^(IDW-1), 2^IDW). It is also late if its offset is 0 while the expected event retires at the same edge for reasons already held in the matrix.
- R7: The first early or late trailer seen while no interrupt is pending sets irq_pend. It also captures irq_src, irq_id and irq_early (1 for early, 0 for late). Further early or late trailers while irq_pend is set only set irq_ovr. irq_ack clears irq_pend and irq_ovr. An event in the same cycle as irq_ack is captured as new.
- R8: ld_valid loads exp_id from ld_id at the next edge and clears the whole matrix. Any trailer or resync presented in the same cycle is ignored, and no event retires in that cycle.
- R9: resync_valid erases every recorded trailer of source resync_src in all rows of the window. Trailers then have to arrive again before a row that needs that source can complete.
- R10: Queued identifiers come out in order on out_id and out_forced while out_valid is 1, and out_rd removes the head entry. fifo_full is 1 when DEPTH entries are held. A write while the queue is full is dropped and sets fifo_fatal, which stays set until reset.
- R11: Identifier arithmetic wraps modulo 2^IDW. The event after identifier 2^IDW-1 is identifier 0.
- R12: A trailer with trl_src >= NSRC is ignored. It is not recorded and raises neither early nor late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trl_valid | input | 1 | Trailer strobe |
| trl_src | input | SW | Source index of the trailer |
| trl_id | input | IDW | Event identifier carried by the trailer |
| ld_valid | input | 1 | Load the expected identifier |
| ld_id | input | IDW | Value to load |
| resync_valid | input | 1 | Erase one source's column |
| resync_src | input | SW | Source to resynchronise |
| src_en | input | NSRC | Source-present mask (1 = present) |
| irq_ack | input | 1 | Clear pending interrupt and overrun |
| out_rd | input | 1 | Pop the queue head |
| exp_id | output | IDW | Expected event identifier |
| out_valid | output | 1 | Queue holds at least one entry |
| out_id | output | IDW | Identifier at queue head |
| out_forced | output | 1 | Head entry was abandoned (incomplete) |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| fifo_fatal | output | 1 | Sticky: a write was lost to a full queue |
| irq_pend | output | 1 | Early/late interrupt pending |
| irq_early | output | 1 | Captured kind: 1 early, 0 late |
| irq_ovr | output | 1 | Further early/late seen while pending |
| irq_src | output | SW | Captured source number |
| irq_id | output | IDW | Captured event identifier |

## Verification
The bench builds the tracker with 6 sources, a 4-row window, 5-bit identifiers and an 8-entry queue. With these values the identifier wraps every 32 events, so random runs cross the modulo boundary many times. The 3-bit source field also leaves two out-of-range indices, 6 and 7. Queue overflow and early offsets just past the narrow window are reachable within a few cycles. A masking sweep therefore fills the queue, and random offsets often fall on the window edge, behind the window, and on the tie where an offset-0 trailer meets a retirement in the same cycle.

// File: rtl/evtrk_pkg.sv
package evtrk_pkg;

  // Kind of skew reported by the interrupt record
  typedef enum logic {SKEW_LATE = 1'b0, SKEW_EARLY = 1'b1} skew_e;

  // Distance from base to id, modulo 2^w
  function automatic logic [31:0] id_offset(input logic [31:0] id,
                                            input logic [31:0] base,
                                            input int unsigned w);
    logic [31:0] msk;
    msk = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (id - base) & msk;
  endfunction

  // True when a modulo offset lies in the upper (behind) half
  function automatic logic is_behind(input logic [31:0] off,
                                     input int unsigned w);
    return off[w-1];
  endfunction

endpackage

// File: rtl/evtrk_classify.sv
module evtrk_classify
  import evtrk_pkg::*;
#(
  parameter int NSRC = 18,
  parameter int WIN  = 16,
  parameter int IDW  = 12,
  parameter int SW   = 5,
  parameter int PW   = 4
) (
  input  logic           trl_go,
  input  logic [SW-1:0]  trl_src,
  input  logic [IDW-1:0] trl_id,
  input  logic [IDW-1:0] exp_id,
  input  logic           retire,
  output logic           early,
  output logic           late,
  output logic           record,
  output logic [PW-1:0]  phys
);
  logic [IDW-1:0] off;
  logic           src_ok, behind, inwin, zero_clash;

  assign off        = IDW'(id_offset(32'(trl_id), 32'(exp_id), IDW));
  assign src_ok     = trl_go && (32'(trl_src) < NSRC);
  assign behind     = is_behind(32'(off), IDW);
  assign inwin      = !behind && (32'(off) < WIN);
  assign zero_clash = retire && (off == '0);

  assign late   = src_ok && (behind || zero_clash);
  assign early  = src_ok && !behind && !inwin;
  assign record = src_ok && inwin && !zero_clash;
  assign phys   = trl_id[PW-1:0];
endmodule

// File: rtl/evtrk_matrix.sv
module evtrk_matrix #(
  parameter int NSRC = 18,
  parameter int WIN  = 16,
  parameter int SW   = 5,
  parameter int PW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_all,
  input  logic            set_en,
  input  logic [PW-1:0]   set_phys,
  input  logic [SW-1:0]   set_src,
  input  logic            rowclr_en,
  input  logic [PW-1:0]   rowclr_phys,
  input  logic            colclr_en,
  input  logic [SW-1:0]   colclr_src,
  input  logic [NSRC-1:0] src_en,
  input  logic [PW-1:0]   base_phys,
  output logic [WIN-1:0]  row_done
);
  // Rows are held at physical slot id mod WIN; no shifting on advance
  logic [NSRC-1:0] bits [WIN];
  logic [NSRC-1:0] nxt  [WIN];
  logic [NSRC-1:0] sel_set, sel_clr;

  assign sel_set = NSRC'(1) << set_src;
  assign sel_clr = NSRC'(1) << colclr_src;

  always_comb begin
    for (int p = 0; p < WIN; p++) begin
      nxt[p] = bits[p];
      if (rowclr_en && rowclr_phys == PW'(p)) nxt[p] = '0;
      if (set_en && set_phys == PW'(p))       nxt[p] = nxt[p] | sel_set;
      if (colclr_en)                          nxt[p] = nxt[p] & ~sel_clr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < WIN; p++) bits[p] <= '0;
    end else begin
      for (int p = 0; p < WIN; p++) bits[p] <= clear_all ? '0 : nxt[p];
    end
  end

  // Completion by logical offset from the expected event
  always_comb begin
    for (int r = 0; r < WIN; r++) begin
      logic [PW-1:0] ph;
      ph          = base_phys + PW'(r);
      row_done[r] = &(bits[ph] | ~src_en);
    end
  end
endmodule

// File: rtl/evtrk_fifo.sv
module evtrk_fifo #(
  parameter int W     = 13,
  parameter int DEPTH = 128,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          valid,
  output logic          full,
  output logic          push_ok,
  output logic [CW-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          pop_ok;

  assign full    = (level == CW'(DEPTH));
  assign valid   = (level != '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && valid;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      level <= level + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/evt_tracker.sv
module evt_tracker
  import evtrk_pkg::*;
#(
  parameter int NSRC  = 18,
  parameter int WIN   = 16,
  parameter int IDW   = 12,
  parameter int DEPTH = 128,
  localparam int SW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trl_valid,
  input  logic [SW-1:0]   trl_src,
  input  logic [IDW-1:0]  trl_id,
  input  logic            ld_valid,
  input  logic [IDW-1:0]  ld_id,
  input  logic            resync_valid,
  input  logic [SW-1:0]   resync_src,
  input  logic [NSRC-1:0] src_en,
  input  logic            irq_ack,
  input  logic            out_rd,
  output logic [IDW-1:0]  exp_id,
  output logic            out_valid,
  output logic [IDW-1:0]  out_id,
  output logic            out_forced,
  output logic            fifo_full,
  output logic            fifo_fatal,
  output logic            irq_pend,
  output logic            irq_early,
  output logic            irq_ovr,
  output logic [SW-1:0]   irq_src,
  output logic [IDW-1:0]  irq_id
);
  localparam int PW = $clog2(WIN);
  localparam int CW = $clog2(DEPTH + 1);

  // Named internal events for the checker
  logic [WIN-1:0] row_done;
  logic           adv_base, adv, early_evt, late_evt, rec_evt;
  logic           trl_go, rsy_go, push_ok;
  logic [PW-1:0]  rec_phys;
  logic [CW-1:0]  fifo_level;
  logic [IDW:0]   head;
  skew_e          kind;

  assign trl_go   = trl_valid && !ld_valid;
  assign rsy_go   = resync_valid && !ld_valid;
  assign adv_base = |row_done;
  assign adv      = !ld_valid && (adv_base || early_evt);
  assign kind     = early_evt ? SKEW_EARLY : SKEW_LATE;

  evtrk_classify #(.NSRC(NSRC), .WIN(WIN), .IDW(IDW), .SW(SW), .PW(PW)) u_cls (
    .trl_go (trl_go),
    .trl_src(trl_src),
    .trl_id (trl_id),
    .exp_id (exp_id),
    .retire (adv_base),
    .early  (early_evt),
    .late   (late_evt),
    .record (rec_evt),
    .phys   (rec_phys)
  );

  evtrk_matrix #(.NSRC(NSRC), .WIN(WIN), .SW(SW), .PW(PW)) u_mat (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_all  (ld_valid),
    .set_en     (rec_evt),
    .set_phys   (rec_phys),
    .set_src    (trl_src),
    .rowclr_en  (adv),
    .rowclr_phys(exp_id[PW-1:0]),
    .colclr_en  (rsy_go),
    .colclr_src (resync_src),
    .src_en     (src_en),
    .base_phys  (exp_id[PW-1:0]),
    .row_done   (row_done)
  );

  evtrk_fifo #(.W(IDW + 1), .DEPTH(DEPTH), .CW(CW)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (adv),
    .din    ({!row_done[0], exp_id}),
    .pop    (out_rd),
    .dout   (head),
    .valid  (out_valid),
    .full   (fifo_full),
    .push_ok(push_ok),
    .level  (fifo_level)
  );

  assign out_forced = head[IDW];
  assign out_id     = head[IDW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_id     <= '0;
      fifo_fatal <= 1'b0;
    end else begin
      if (ld_valid) exp_id <= ld_id;
      else if (adv) exp_id <= exp_id + 1'b1;
      if (adv && !push_ok) fifo_fatal <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pend  <= 1'b0;
      irq_ovr   <= 1'b0;
      irq_early <= 1'b0;
      irq_src   <= '0;
      irq_id    <= '0;
    end else begin
      logic pend_n, ovr_n;
      pend_n = irq_ack ? 1'b0 : irq_pend;
      ovr_n  = irq_ack ? 1'b0 : irq_ovr;
      if (early_evt || late_evt) begin
        if (pend_n) begin
          ovr_n = 1'b1;
        end else begin
          pend_n = 1'b1;
          irq_early <= (kind == SKEW_EARLY);
          irq_src   <= trl_src;
          irq_id    <= trl_id;
        end
      end
      irq_pend <= pend_n;
      irq_ovr  <= ovr_n;
    end
  end
endmodule

// File: rtl/evt_tracker_chk.sv
module evt_tracker_chk #(
  parameter int IDW   = 12,
  parameter int DEPTH = 128,
  parameter int CW    = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ld_valid,
  input logic [IDW-1:0] ld_id,
  input logic [IDW-1:0] exp_id,
  input logic           adv,
  input logic           early_evt,
  input logic           late_evt,
  input logic           out_rd,
  input logic           fifo_full,
  input logic           fifo_fatal,
  input logic [CW-1:0]  fifo_level,
  input logic           irq_pend,
  input logic           irq_ovr
);
  // R2
  exp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> (exp_id == $past(exp_id)) || (exp_id == IDW'($past(exp_id) + 1'b1)));

  // R8
  exp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> exp_id == $past(ld_id));

  // R5
  panic_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_evt |=> exp_id == IDW'($past(exp_id) + 1'b1));

  // R6
  skew_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(early_evt && late_evt));

  // R7
  ovr_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovr |-> irq_pend);

  // R10
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= CW'(DEPTH));

  // R10
  fatal_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && fifo_full) |=> fifo_fatal);

  // R10
  fatal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_fatal |=> fifo_fatal);

  // R10
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !out_rd) |=> $stable(fifo_level));
endmodule

bind evt_tracker evt_tracker_chk #(.IDW(IDW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_valid  (ld_valid),
  .ld_id     (ld_id),
  .exp_id    (exp_id),
  .adv       (adv),
  .early_evt (early_evt),
  .late_evt  (late_evt),
  .out_rd    (out_rd),
  .fifo_full (fifo_full),
  .fifo_fatal(fifo_fatal),
  .fifo_level(fifo_level),
  .irq_pend  (irq_pend),
  .irq_ovr   (irq_ovr)
);

// File: tb/sim_evt_tracker.sv
module sim_evt_tracker;
  localparam int NS  = 6;
  localparam int WN  = 4;
  localparam int IW  = 5;
  localparam int DP  = 8;
  localparam int SWB = 3;
  localparam int M   = 1 << IW;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trl_valid = 0, ld_valid = 0, resync_valid = 0, irq_ack = 0, out_rd = 0;
  logic [SWB-1:0] trl_src = '0, resync_src = '0, irq_src;
  logic [IW-1:0]  trl_id = '0, ld_id = '0, exp_id, out_id, irq_id;
  logic [NS-1:0]  src_en = '1;
  logic out_valid, out_forced, fifo_full, fifo_fatal, irq_pend, irq_early, irq_ovr;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_tracker #(.NSRC(NS), .WIN(WN), .IDW(IW), .DEPTH(DP)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string cur_tag = "R1";

  // ---------------- reference model ----------------
  logic [NS-1:0] del [M];
  int unsigned   m_exp;
  logic [IW:0]   m_q [DP];
  int unsigned   m_hd, m_cnt;
  logic          m_fatal, m_pend, m_ovr, m_early;
  int unsigned   m_src, m_id;

  function automatic bit rowc(int unsigned id);
    return &(del[id % M] | ~src_en);
  endfunction

  function automatic int unsigned offs(int unsigned id, int unsigned base);
    return (id + M - base) % M;
  endfunction

  always @(posedge clk) begin
    bit c0, cl, base, vs, lt, er, rc, adv, popk;
    int unsigned off;
    if (!rst_n) begin
      for (int i = 0; i < M; i++) del[i] = '0;
      m_exp = 0; m_hd = 0; m_cnt = 0; m_fatal = 0;
      m_pend = 0; m_ovr = 0; m_early = 0; m_src = 0; m_id = 0;
    end else begin
      popk = out_rd && (m_cnt > 0);
      lt = 0; er = 0; adv = 0; c0 = 0;
      if (ld_valid) begin
        for (int i = 0; i < M; i++) del[i] = '0;
        m_exp = ld_id;
      end else begin
        c0 = rowc(m_exp);
        cl = 0;
        for (int k = 1; k < WN; k++) if (rowc(m_exp + k)) cl = 1;
        base = c0 || cl;
        vs  = trl_valid && (trl_src < NS);
        off = offs(trl_id, m_exp);
        lt  = vs && (off >= M/2 || (base && off == 0));
        er  = vs && off < M/2 && off >= WN;
        rc  = vs && !lt && !er;
        adv = base || er;
        if (rc) del[trl_id] = del[trl_id] | (NS'(1) << trl_src);
        if (adv) del[m_exp % M] = '0;
        if (resync_valid && resync_src < NS)
          for (int i = 0; i < M; i++) del[i][resync_src] = 1'b0;
      end
      if (irq_ack) begin m_pend = 0; m_ovr = 0; end
      if (lt || er) begin
        if (m_pend) m_ovr = 1;
        else begin m_pend = 1; m_early = er; m_src = trl_src; m_id = trl_id; end
      end
      if (adv) begin
        if (m_cnt == DP) m_fatal = 1;
        else begin
          m_q[(m_hd + m_cnt) % DP] = {!c0, IW'(m_exp)};
          m_cnt++;
        end
      end
      if (popk) begin m_hd = (m_hd + 1) % DP; m_cnt--; end
      if (adv) m_exp = (m_exp + 1) % M;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic compare_all();
    chk(cur_tag, "exp_id", 32'(exp_id), m_exp);
    chk(cur_tag, "out_valid", 32'(out_valid), 32'(m_cnt > 0));
    chk(cur_tag, "fifo_full", 32'(fifo_full), 32'(m_cnt == DP));
    chk("R10", "fifo_fatal", 32'(fifo_fatal), 32'(m_fatal));
    if (m_cnt > 0) begin
      chk(cur_tag, "out_id", 32'(out_id), 32'(m_q[m_hd][IW-1:0]));
      chk(cur_tag, "out_forced", 32'(out_forced), 32'(m_q[m_hd][IW]));
    end
    chk("R7", "irq_pend", 32'(irq_pend), 32'(m_pend));
    chk("R7", "irq_ovr", 32'(irq_ovr), 32'(m_ovr));
    if (m_pend) begin
      chk("R7", "irq_early", 32'(irq_early), 32'(m_early));
      chk("R7", "irq_src", 32'(irq_src), m_src);
      chk("R7", "irq_id", 32'(irq_id), m_id);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic send(int unsigned s, int unsigned id);
    trl_valid = 1; trl_src = SWB'(s); trl_id = IW'(id);
    step();
    trl_valid = 0;
  endtask

  task automatic send_all(int unsigned id);
    for (int s = 0; s < NS; s++) send(s, id);
  endtask

  task automatic pop_n(int n);
    out_rd = 1;
    repeat (n) step();
    out_rd = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "exp_id", 32'(exp_id), 0);
    chk("R1", "out_valid", 32'(out_valid), 0);
    chk("R1", "irq_pend", 32'(irq_pend), 0);
    chk("R1", "fifo_fatal", 32'(fifo_fatal), 0);

    // R2 normal completion
    cur_tag = "R2";
    send_all(0); step();
    chk("R2", "exp after complete", 32'(exp_id), 1);
    chk("R2", "head id", 32'(out_id), 0);
    chk("R2", "head forced", 32'(out_forced), 0);

    // R3 masked source counts as delivered
    cur_tag = "R3"; src_en = 6'b011111;
    for (int s = 0; s < NS - 1; s++) send(s, 1);
    step();
    chk("R3", "exp with masked src", 32'(exp_id), 2);
    src_en = '1;
    pop_n(2);
    chk("R10", "empty after pops", 32'(out_valid), 0);

    // R4 later event completes first
    cur_tag = "R4";
    send_all(3); step();
    chk("R4", "exp after forced", 32'(exp_id), 3);
    chk("R4", "forced id", 32'(out_id), 2);
    chk("R4", "forced flag", 32'(out_forced), 1);
    step();
    chk("R4", "exp after later", 32'(exp_id), 4);
    pop_n(2);

    // R5 panic on early trailer
    cur_tag = "R5";
    send(2, 9);
    chk("R5", "exp after panic", 32'(exp_id), 5);
    chk("R5", "panic id", 32'(out_id), 4);
    chk("R5", "irq early", 32'(irq_early), 1);
    chk("R5", "irq src", 32'(irq_src), 2);
    chk("R5", "irq id", 32'(irq_id), 9);
    pop_n(1);
    irq_ack = 1; step(); irq_ack = 0;

    // R6 late trailer, R7 overrun
    cur_tag = "R6";
    send(1, 2);
    chk("R6", "late pend", 32'(irq_pend), 1);
    chk("R6", "late kind", 32'(irq_early), 0);
    chk("R6", "exp unchanged", 32'(exp_id), 5);
    cur_tag = "R7";
    send(3, 1);
    chk("R7", "overrun", 32'(irq_ovr), 1);
    chk("R7", "first src kept", 32'(irq_src), 1);
    irq_ack = 1; step(); irq_ack = 0;
    chk("R7", "ack clears", 32'(irq_pend), 0);

    // R8 load ignores concurrent trailer
    cur_tag = "R8";
    ld_valid = 1; ld_id = 5'd30;
    send(0, 6);
    ld_valid = 0;
    chk("R8", "loaded exp", 32'(exp_id), 30);
    chk("R8", "no irq", 32'(irq_pend), 0);

    // R11 wrap
    cur_tag = "R11";
    send_all(30); step();
    send_all(31); step();
    send_all(0);  step();
    chk("R11", "exp wrapped", 32'(exp_id), 1);
    chk("R11", "head 30", 32'(out_id), 30);
    pop_n(1);
    chk("R11", "head 31", 32'(out_id), 31);
    pop_n(1);
    chk("R11", "head 0", 32'(out_id), 0);
    pop_n(1);

    // R9 resync erases a column
    cur_tag = "R9";
    for (int s = 0; s < NS - 1; s++) send(s, 1);
    resync_valid = 1; resync_src = 3'd4; step(); resync_valid = 0;
    send(5, 1); step();
    chk("R9", "held after resync", 32'(exp_id), 1);
    send(4, 1); step();
    chk("R9", "completes after resend", 32'(exp_id), 2);
    pop_n(1);

    // R12 out-of-range source ignored
    cur_tag = "R12";
    send(7, 12); send(6, 30);
    chk("R12", "no irq", 32'(irq_pend), 0);
    chk("R12", "exp unchanged", 32'(exp_id), 2);

    // R10 overflow with all sources masked
    cur_tag = "R10"; src_en = '0;
    repeat (10) step();
    src_en = '1;
    chk("R10", "full", 32'(fifo_full), 1);
    chk("R10", "fatal", 32'(fifo_fatal), 1);
    chk("R10", "oldest first", 32'(out_id), 2);
    pop_n(DP);
    chk("R10", "drained", 32'(out_valid), 0);

    // Random phase
    rst_n = 0; step(); rst_n = 1; step();
    cur_tag = "R2/R4/R5/R6/R9/R11 random";
    for (int i = 0; i < 4000; i++) begin
      int unsigned r, off;
      r = $urandom % 100;
      trl_valid = (r < 75);
      trl_src = ($urandom % 16 == 0) ? SWB'(6 + $urandom % 2) : SWB'($urandom % NS);
      r = $urandom % 20;
      if (r < 15)      off = $urandom % WN;
      else if (r < 17) off = WN + $urandom % 4;
      else             off = M - 1 - ($urandom % 3);
      trl_id = IW'((m_exp + off) % M);
      src_en = ($urandom % 50 == 0) ? NS'($urandom) : '1;
      out_rd = ($urandom % 10) < 6;
      irq_ack = ($urandom % 10) == 0;
      resync_valid = ($urandom % 50) == 0;
      resync_src = SWB'($urandom % 8);
      ld_valid = ($urandom % 300) == 0;
      ld_id = IW'($urandom);
      step();
    end
    trl_valid = 0; out_rd = 0; irq_ack = 0; resync_valid = 0; ld_valid = 0;
    step();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule